// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block finds the divider settings for a programmable clock synthesizer fed by a 14.31818 MHz reference. The synthesizer output is ref × M / (N1 × 2^N2), and its internal oscillator runs at ref × M / N1, which must stay inside a window given on the inputs. A host pulses `start` with a requested frequency in kHz, a lowest allowed post-divider exponent and the oscillator window limits. The engine checks that the request is reachable at all. It then sweeps every (N2, N1) pair and keeps the divider triple with the smallest error.

The result is returned already packed as the two byte values a synthesizer register pair expects. One byte holds M minus 2. The other holds N1 minus 2 in the low field and N2 above it. A one-cycle `done` pulse closes every request, and `ok` reports whether the request passed the reachability check. All arithmetic is exact integer work. The reference is held as 1431818 in units of 10 Hz, and errors are compared as cross-multiplied fractions, so no rounding enters the comparison. One pair is evaluated per pass of a sequential divider.

Top module: `pll_param_search`

## Requirements
- R1: After reset `busy`, `done`, `ok`, `m_byte` and `n_byte` are all 0.
- R2: A request with `freq_khz` < floor(`vco_min_khz`/8) or `freq_khz` > floor(`vco_max_khz` / 2^`min_n2`) is rejected. `done` rises in the cycle after `start` is sampled, `ok` is 0, `busy` stays 0, and `m_byte`/`n_byte` keep their previous values. Requests exactly at either limit are accepted.
- R3: An accepted request sweeps N2 from `min_n2` up to 3 (outer) and N1 from 3 up to 33 (inner). For each pair M = floor((f·100·N1·2^N2 + 715909) / 1431818), with f in kHz. Pairs with M outside 3..129 are discarded.
- R4: A pair is a candidate only if the oscillator frequency 14318.18·M/N1 kHz lies in [`vco_min_khz`, `vco_max_khz`], both ends inclusive.
- R5: The kept triple changes only when a candidate's absolute error |f − 14318.18·M/(N1·2^N2)| is strictly below the kept error, so on a tie the earlier pair in sweep order wins. Before the sweep the kept error equals f and the kept triple is M=127, N1=18, N2=2.
- R6: On success `m_byte` = M − 2. `n_byte` carries N1 − 2 in bits 4:0 and N2 in bits 6:5, and bit 7 is 0. The fallback triple therefore packs to 125 and 80.
- R7: `done` is high for exactly one cycle per request. `ok` is 1 after an accepted request. `m_byte`, `n_byte` and `ok` change only in a cycle where `done` is high.
- R8: `start` is ignored while `busy` is high. Neither its inputs nor the pulse alter the running search, and no second search follows it.
- R9: `busy` is high from the cycle after an accepted `start` until `done` rises, and low in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled while idle |
| freq_khz | input | FREQ_W | Requested output frequency in kHz |
| min_n2 | input | 2 | Lowest post-divider exponent to try |
| vco_min_khz | input | FREQ_W | Lower oscillator limit in kHz |
| vco_max_khz | input | FREQ_W | Upper oscillator limit in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last request was reachable |
| m_byte | output | 8 | Packed M value (M − 2) |
| n_byte | output | 8 | Packed N1 − 2 and N2 |

## Verification
The bench aims at both edges of the reachability check. Requests sit exactly at vco_min/8 and at vco_max/2^min_n2, and one step beyond each. An off-by-one comparison there would reject a legal request or return garbage for an illegal one. A one-point oscillator window that no integer triple can hit must return the fallback bytes 125 and 80. A design that seeds the wrong default, or accepts out-of-window pairs, shows up there. A `start` pulse with a different frequency in the middle of a sweep must leave the result unchanged. A rejected request after a good one must keep the old bytes, which catches a design that clears or overwrites them on failure.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    // Reference clock in units of 10 Hz (14318.18 kHz x 100)
    localparam int unsigned REF_X100 = 1431818;
    localparam int unsigned REF_HALF = 715909;
    localparam int          REF_W    = 21;
    localparam int          M_LO     = 3;
    localparam int          M_HI     = 129;
    localparam int          N1_LO    = 3;
    localparam int          N1_HI    = 33;
    localparam int          N2_HI    = 3;
    localparam int          M_SEED   = 127;
    localparam int          N1_SEED  = 18;
    localparam int          N2_SEED  = 2;
    localparam int          DEN_W    = 9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KICK = 2'd1,
        ST_WAIT = 2'd2
    } search_st_e;
endpackage

// File: rtl/pll_round_div.sv
module pll_round_div #(
    parameter int W  = 36,
    parameter int DW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [W-1:0]  numer,
    input  logic [DW-1:0] denom,
    output logic [W-1:0]  quo,
    output logic          fin
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [W-1:0]  acc;
        logic          fin;
    } div_t;

    div_t        s_d, s_q;
    logic [DW:0] trial;
    logic        ge;

    always_comb begin
        s_d   = s_q;
        s_d.fin = 1'b0;
        trial = {s_q.rem, s_q.acc[W-1]};
        ge    = trial >= {1'b0, denom};
        if (go) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(W);
            s_d.rem  = '0;
            s_d.acc  = numer;
        end else if (s_q.busy) begin
            s_d.rem = ge ? DW'(trial - {1'b0, denom}) : trial[DW-1:0];
            s_d.acc = {s_q.acc[W-2:0], ge};
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign quo = s_q.acc;
    assign fin = s_q.fin;

    // R3: a new division is only launched on an idle divider
    assert_div_idle_on_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !s_q.busy);
    // R3: the quotient-ready strobe is a single cycle
    assert_div_fin_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
    import pll_search_pkg::*;
#(
    parameter int FREQ_W = 20,
    parameter int PROD_W = 36
) (
    input  logic [PROD_W-1:0] tgt,
    input  logic [PROD_W-1:0] quo,
    input  logic [5:0]        n1,
    input  logic [1:0]        n2,
    input  logic [FREQ_W-1:0] vmin,
    input  logic [FREQ_W-1:0] vmax,
    input  logic [PROD_W-1:0] best_num,
    input  logic [DEN_W-1:0]  best_den,
    output logic              better,
    output logic [7:0]        m8,
    output logic [PROD_W-1:0] err,
    output logic [DEN_W-1:0]  den
);
    localparam int XW = PROD_W + 1;
    localparam int CW = PROD_W + DEN_W;

    logic          m_ok, in_win;
    logic [XW-1:0] refm, lo, hi, tgt_x, diff;
    logic [CW-1:0] lhs, rhs;

    always_comb begin
        m_ok   = (quo >= PROD_W'(M_LO)) && (quo <= PROD_W'(M_HI));
        m8     = quo[7:0];
        refm   = XW'(REF_X100) * XW'(m8);
        lo     = XW'(vmin) * XW'(100) * XW'(n1);
        hi     = XW'(vmax) * XW'(100) * XW'(n1);
        in_win = (refm >= lo) && (refm <= hi);
        tgt_x  = XW'(tgt);
        diff   = (tgt_x >= refm) ? tgt_x - refm : refm - tgt_x;
        err    = PROD_W'(diff);
        den    = DEN_W'({3'b000, n1} << n2);
        lhs    = CW'(err) * CW'(best_den);
        rhs    = CW'(best_num) * CW'(den);
        better = m_ok && in_win && (lhs < rhs);
    end
endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
    import pll_search_pkg::*;
#(
    parameter int FREQ_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_khz,
    input  logic [1:0]        min_n2,
    input  logic [FREQ_W-1:0] vco_min_khz,
    input  logic [FREQ_W-1:0] vco_max_khz,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic [7:0]        m_byte,
    output logic [7:0]        n_byte
);
    // f*100 needs 7 more bits, N1 6 bits, 2^N2 3 bits
    localparam int PROD_W = FREQ_W + 16;

    typedef struct packed {
        search_st_e        st;
        logic [FREQ_W-1:0] fin;
        logic [FREQ_W-1:0] vmin;
        logic [FREQ_W-1:0] vmax;
        logic [1:0]        n2;
        logic [5:0]        n1;
        logic [PROD_W-1:0] b_num;
        logic [DEN_W-1:0]  b_den;
        logic [7:0]        b_m;
        logic [5:0]        b_n1;
        logic [1:0]        b_n2;
        logic              done;
        logic              ok;
        logic [7:0]        m_out;
        logic [7:0]        n_out;
    } ctl_t;

    ctl_t              r_d, r_q;
    logic              too_low, too_high, last;
    logic [PROD_W-1:0] tgt, numer, quo, err;
    logic              div_go, div_fin, better;
    logic [7:0]        m8, nb_m;
    logic [DEN_W-1:0]  den;
    logic [5:0]        nb_n1;
    logic [1:0]        nb_n2;

    assign too_low  = freq_khz < (vco_min_khz >> 3);
    assign too_high = freq_khz > (vco_max_khz >> min_n2);
    assign tgt      = (PROD_W'(r_q.fin) * PROD_W'(100) * PROD_W'(r_q.n1)) << r_q.n2;
    assign numer    = tgt + PROD_W'(REF_HALF);
    assign div_go   = (r_q.st == ST_KICK);

    pll_round_div #(.W(PROD_W), .DW(REF_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .numer (numer),
        .denom (REF_W'(REF_X100)),
        .quo   (quo),
        .fin   (div_fin)
    );

    pll_cand_eval #(.FREQ_W(FREQ_W), .PROD_W(PROD_W)) u_eval (
        .tgt      (tgt),
        .quo      (quo),
        .n1       (r_q.n1),
        .n2       (r_q.n2),
        .vmin     (r_q.vmin),
        .vmax     (r_q.vmax),
        .best_num (r_q.b_num),
        .best_den (r_q.b_den),
        .better   (better),
        .m8       (m8),
        .err      (err),
        .den      (den)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        nb_m     = better ? m8     : r_q.b_m;
        nb_n1    = better ? r_q.n1 : r_q.b_n1;
        nb_n2    = better ? r_q.n2 : r_q.b_n2;
        last     = (r_q.n2 == 2'(N2_HI)) && (r_q.n1 == 6'(N1_HI));
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (too_low || too_high) begin
                        r_d.done = 1'b1;
                        r_d.ok   = 1'b0;
                    end else begin
                        r_d.st    = ST_KICK;
                        r_d.fin   = freq_khz;
                        r_d.vmin  = vco_min_khz;
                        r_d.vmax  = vco_max_khz;
                        r_d.n2    = min_n2;
                        r_d.n1    = 6'(N1_LO);
                        r_d.b_num = PROD_W'(freq_khz) * PROD_W'(100);
                        r_d.b_den = DEN_W'(1);
                        r_d.b_m   = 8'(M_SEED);
                        r_d.b_n1  = 6'(N1_SEED);
                        r_d.b_n2  = 2'(N2_SEED);
                    end
                end
            end
            ST_KICK: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (div_fin) begin
                    if (better) begin
                        r_d.b_num = err;
                        r_d.b_den = den;
                    end
                    r_d.b_m  = nb_m;
                    r_d.b_n1 = nb_n1;
                    r_d.b_n2 = nb_n2;
                    if (last) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.ok    = 1'b1;
                        r_d.m_out = nb_m - 8'd2;
                        r_d.n_out = {1'b0, nb_n2, 5'(nb_n1 - 6'd2)};
                    end else begin
                        r_d.st = ST_KICK;
                        if (r_q.n1 == 6'(N1_HI)) begin
                            r_d.n1 = 6'(N1_LO);
                            r_d.n2 = r_q.n2 + 2'd1;
                        end else begin
                            r_d.n1 = r_q.n1 + 6'd1;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign done   = r_q.done;
    assign ok     = r_q.ok;
    assign m_byte = r_q.m_out;
    assign n_byte = r_q.n_out;

    // R7: completion strobe lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: result outputs move only together with done
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(m_byte) || !$stable(n_byte) || !$stable(ok)) |-> done);
    // R2: a rejected request keeps the previous bytes
    assert_reject_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> ($stable(m_byte) && $stable(n_byte)));
    // R6: packed bytes stay inside their legal fields
    assert_pack_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (!n_byte[7] && n_byte[4:0] != 5'd0 && m_byte >= 8'd1 && m_byte <= 8'd127));
    // R8: a start seen while searching leaves the latched request alone
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(r_q.fin));
    // R3: the inner index never leaves its sweep span
    assert_n1_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.n1 >= 6'(N1_LO) && r_q.n1 <= 6'(N1_HI)));
    // R9: busy is down whenever done is raised
    assert_busy_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/tb_pll_param_search.sv
module tb_pll_param_search;
    localparam int FREQ_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [FREQ_W-1:0] freq_khz = '0;
    logic [1:0]        min_n2 = '0;
    logic [FREQ_W-1:0] vco_min_khz = '0;
    logic [FREQ_W-1:0] vco_max_khz = '0;
    logic              busy, done, ok;
    logic [7:0]        m_byte, n_byte;

    int n_chk  = 0;
    int n_fail = 0;
    int held_m = 0, held_n = 0, held_ok = 0;

    always #4 clk = ~clk;

    pll_param_search #(.FREQ_W(FREQ_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_khz(freq_khz),
        .min_n2(min_n2), .vco_min_khz(vco_min_khz), .vco_max_khz(vco_max_khz),
        .busy(busy), .done(done), .ok(ok), .m_byte(m_byte), .n_byte(n_byte)
    );

    task automatic chk(input bit cond, input string req, input longint act, input longint exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference: exhaustive search with exact rational errors
    task automatic ref_search(input longint f, input longint mn2, input longint vmin,
                              input longint vmax, output int e_ok, output int e_m,
                              output int e_n);
        longint bn, bd, bm, b1, b2;
        if (f < vmin / 8 || f > (vmax >> mn2)) begin
            e_ok = 0; e_m = held_m; e_n = held_n;
            return;
        end
        bn = f * 100; bd = 1; bm = 127; b1 = 18; b2 = 2;
        for (longint p2 = mn2; p2 <= 3; p2++) begin
            for (longint p1 = 3; p1 <= 33; p1++) begin
                longint t, m, r, e, d;
                t = f * 100 * p1 * (64'd1 << p2);
                m = (t + 715909) / 1431818;
                if (m < 3 || m > 129) continue;
                r = 1431818 * m;
                if (r < vmin * 100 * p1 || r > vmax * 100 * p1) continue;
                e = (t > r) ? t - r : r - t;
                d = p1 * (64'd1 << p2);
                if (e * bd < bn * d) begin
                    bn = e; bd = d; bm = m; b1 = p1; b2 = p2;
                end
            end
        end
        e_ok = 1;
        e_m  = int'(bm - 2);
        e_n  = int'((b1 - 2) | (b2 << 5));
    endtask

    task automatic run_req(input int f, input int mn2, input int vmin, input int vmax,
                           input bit poke, input string tag);
        int e_ok, e_m, e_n, cyc;
        bit seen;
        ref_search(f, mn2, vmin, vmax, e_ok, e_m, e_n);
        @(negedge clk);
        freq_khz = FREQ_W'(f); min_n2 = 2'(mn2);
        vco_min_khz = FREQ_W'(vmin); vco_max_khz = FREQ_W'(vmax);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (e_ok == 0) begin
            chk(done == 1'b1, {"R2 reject done ", tag}, done, 1);
            chk(ok == 1'b0, {"R2 reject ok ", tag}, ok, 0);
            chk(busy == 1'b0, {"R2 reject busy ", tag}, busy, 0);
            chk(m_byte == 8'(held_m), {"R2 keep m ", tag}, m_byte, held_m);
            chk(n_byte == 8'(held_n), {"R2 keep n ", tag}, n_byte, held_n);
            held_ok = 0;
            @(negedge clk);
            chk(done == 1'b0, {"R7 pulse ", tag}, done, 0);
            return;
        end
        chk(busy == 1'b1, {"R9 busy after start ", tag}, busy, 1);
        chk(done == 1'b0, {"R9 no early done ", tag}, done, 0);
        seen = 1'b0;
        for (cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            if (poke && cyc == 50) begin
                freq_khz = FREQ_W'(f + 7777); min_n2 = 2'd3; start = 1'b1;
            end
            if (poke && cyc == 51) begin
                start = 1'b0;
            end
            if (done) begin
                seen = 1'b1;
                break;
            end
            // R7: results hold between completions, checked every clock
            chk(m_byte == 8'(held_m) && n_byte == 8'(held_n) && ok == held_ok[0],
                {"R7 hold ", tag}, m_byte, held_m);
            chk(busy == 1'b1, {"R9 busy during sweep ", tag}, busy, 1);
        end
        chk(seen, {"watchdog ", tag}, cyc, 20000);
        if (!seen) return;
        chk(busy == 1'b0, {"R9 busy low at done ", tag}, busy, 0);
        chk(ok == 1'b1, {"R7 ok ", tag}, ok, 1);
        chk(m_byte == 8'(e_m), {"R3 R4 R5 R6 m_byte ", tag}, m_byte, e_m);
        chk(n_byte == 8'(e_n), {"R3 R4 R5 R6 n_byte ", tag}, n_byte, e_n);
        held_m = e_m; held_n = e_n; held_ok = 1;
        @(negedge clk);
        chk(done == 1'b0, {"R7 done one cycle ", tag}, done, 0);
        chk(busy == 1'b0, {"R8 no queued search ", tag}, busy, 0);
        chk(m_byte == 8'(held_m) && n_byte == 8'(held_n), {"R7 hold after ", tag}, m_byte, held_m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
        chk(ok == 1'b0, "R1 ok", ok, 0);
        chk(m_byte == 8'd0 && n_byte == 8'd0, "R1 bytes", {m_byte, n_byte}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && m_byte == 8'd0, "R1 after release", busy, 0);

        // R3 R4 R5: ordinary requests
        run_req(25175, 0, 100000, 250000, 1'b0, "25175");
        run_req(65000, 0, 100000, 250000, 1'b0, "65000");
        run_req(108000, 0, 100000, 250000, 1'b0, "108000");
        run_req(20000, 3, 100000, 250000, 1'b0, "20000 n2min3");
        // R2: rejection keeps previous bytes, limits are inclusive
        run_req(12499, 0, 100000, 250000, 1'b0, "below low limit");
        run_req(12500, 0, 100000, 250000, 1'b0, "at low limit");
        run_req(250001, 0, 100000, 250000, 1'b0, "above high limit");
        run_req(250000, 0, 100000, 250000, 1'b0, "at high limit");
        run_req(125001, 1, 100000, 250000, 1'b0, "above high limit n2min1");
        run_req(125000, 1, 100000, 250000, 1'b0, "at high limit n2min1");
        // R5 R6: unreachable single-point window returns the seed triple
        run_req(20000, 0, 100001, 100001, 1'b0, "seed fallback");
        chk(m_byte == 8'd125, "R5 R6 seed m_byte", m_byte, 125);
        chk(n_byte == 8'd80, "R5 R6 seed n_byte", n_byte, 80);
        // R8: start during a sweep is ignored
        run_req(40000, 0, 100000, 250000, 1'b1, "R8 busy poke");
        run_req(31500, 1, 100000, 250000, 1'b0, "31500 n2min1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule